// File: doc/BRIEF.md
# Variable-Length SPI Master Burst Engine

This block is the shifting core of an SPI master. It moves a programmed number of bits in one chip-select burst, from 1 bit up to 4096 bits. Transmit data comes from a transmit FIFO and received data goes to a receive FIFO, always as 32-bit words. The length register holds the bit count minus one. When the count is not a multiple of 32, the first word of the burst carries only the leftover bits, right-aligned. Every word after it is full. The receive side mirrors this layout, so software sees the same packing in both directions.

A run starts with a one-cycle `start` pulse. The engine then performs `repeat_cnt + 1` bursts, all of the same length, and releases chip select between them. The bus runs in SPI mode 0 only. An empty transmit FIFO or a full receive FIFO pauses the serial clock; nothing is lost or invented while it waits. `busy` stays high for the whole run, and a single-cycle `done` pulse closes it.

Top module: `spi_burst_engine`

## Requirements
- R1: `burst_len_m1` holds N-1 and is captured at start. A burst produces exactly N rising SCLK edges while `cs_n` is low. The value 0 gives one bit, and the largest value, 4095, gives 4096 bits.
- R2: Let m = N mod 32, with m taken as 32 when the remainder is 0. The first transmit word of a burst supplies its m lowest bits. Every further word of that burst supplies all 32 bits. The burst pops exactly ceil(N/32) words.
- R3: Transmit word bits at position m and above in a partial first word never appear on MOSI.
- R4: Within each word's valid field, bits go out highest position first. MOSI changes only while SCLK is low. MISO is sampled at the SCLK rising edge.
- R5: The first receive word of a burst holds its m received bits in positions m-1..0, with the earliest bit highest, and zeros above. Each later word holds 32 received bits. A burst writes ceil(N/32) words.
- R6: `cs_n` goes low before the first SCLK rise and returns high after the last bit of each burst. SCLK is never high while `cs_n` is high.
- R7: One start performs `repeat_cnt`+1 bursts, all with the captured length. Between bursts `cs_n` stays high for at least one SCLK period (2*HALF_DIV clock cycles).
- R8: While a word is needed and `tx_valid` is low, SCLK stays low, no edges occur, and `tx_ready` stays high.
- R9: `rx_valid` never pulses in a cycle following one in which `rx_full` was high. The engine waits, with SCLK idle, until space is available.
- R10: `busy` rises in the cycle after an accepted start. It falls in the same cycle that `done` pulses once, for one cycle, after the last burst. A start pulse while busy is ignored.
- R11: Each SCLK high phase lasts exactly HALF_DIV clock cycles.
- R12: After reset: `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `tx_ready`=0, `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| burst_len_m1 | input | LEN_W | Bits per burst minus one |
| repeat_cnt | input | REP_W | Number of extra bursts |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| tx_data | input | WORD_W | Transmit FIFO head word |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_ready | output | 1 | Pop transmit word |
| rx_data | output | WORD_W | Receive word |
| rx_valid | output | 1 | Receive word write strobe |
| rx_full | input | 1 | Receive FIFO full |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with HALF_DIV=2, LEN_W=12 and REP_W=4. The short serial clock keeps a full 4096-bit burst (128 words) well inside the run budget, so the largest length and the one-bit length are both exercised directly. These parameter values also cover a 33-bit burst with a single-bit first word, a 70-bit burst with three words, and a three-burst repeat. The 4-bit repeat field is enough to test gap timing and the single `done` pulse, and the two-cycle half period makes the high-phase length check distinct from one cycle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_LOW, ST_HIGH,
    ST_PUSH, ST_TAIL, ST_GAP1, ST_GAP2
  } eng_state_t;
endpackage

// File: rtl/spi_half_tick.sv
// Free-running half-period timer; restarts whenever disabled.
module spi_half_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_word_shifter.sv
// Left-aligns the valid field of a TX word and collects RX bits from the LSB.
module spi_word_shifter #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_bits,
  input  logic              shift,
  input  logic              sample,
  input  logic              miso_in,
  output logic              mosi_bit,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [CNT_W-1:0]  lsh;

  assign lsh      = CNT_W'(WORD_W) - load_bits;
  assign mosi_bit = tx_sh[WORD_W-1];
  assign rx_word  = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load)       tx_sh <= load_word << lsh;
      else if (shift) tx_sh <= tx_sh << 1;
      if (load)        rx_sh <= '0;
      else if (sample) rx_sh <= {rx_sh[WORD_W-2:0], miso_in};
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned REP_W    = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len_m1,
  input  logic [REP_W-1:0]  repeat_cnt,
  output logic              busy,
  output logic              done,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_full,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1;
  localparam int unsigned BIT_W = LEN_W + 1;

  eng_state_t        state;
  logic [LEN_W-1:0]  len_q;
  logic [REP_W-1:0]  reps_left;
  logic [BIT_W-1:0]  bits_left;
  logic [CNT_W-1:0]  next_bits;
  logic [CNT_W-1:0]  wleft;
  logic              tick, tick_en;
  logic              sh_load, sh_shift, sh_sample;
  logic [WORD_W-1:0] rx_word;

  // Bits carried by the first word of a burst: remainder, or a full word.
  function automatic logic [CNT_W-1:0] first_bits(input logic [LEN_W-1:0] l);
    return CNT_W'(l % LEN_W'(WORD_W)) + CNT_W'(1);
  endfunction

  assign tx_ready  = (state == ST_FETCH);
  assign sh_load   = (state == ST_FETCH) && tx_valid;
  assign sh_sample = (state == ST_LOW)  && tick;
  assign sh_shift  = (state == ST_HIGH) && tick;
  assign tick_en   = (state == ST_SETUP) || (state == ST_LOW) || (state == ST_HIGH) ||
                     (state == ST_TAIL)  || (state == ST_GAP1) || (state == ST_GAP2);

  spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk), .rst (rst), .en (tick_en), .tick (tick)
  );

  spi_word_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_word (tx_data),
    .load_bits (next_bits),
    .shift     (sh_shift),
    .sample    (sh_sample),
    .miso_in   (miso),
    .mosi_bit  (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      len_q     <= '0;
      reps_left <= '0;
      bits_left <= '0;
      next_bits <= '0;
      wleft     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          busy      <= 1'b1;
          len_q     <= burst_len_m1;
          reps_left <= repeat_cnt;
          bits_left <= BIT_W'(burst_len_m1) + BIT_W'(1);
          next_bits <= first_bits(burst_len_m1);
          state     <= ST_FETCH;
        end
        ST_FETCH: if (tx_valid) begin
          wleft <= next_bits;
          if (cs_n) begin
            cs_n  <= 1'b0;
            state <= ST_SETUP;
          end else begin
            state <= ST_LOW;
          end
        end
        ST_SETUP: if (tick) state <= ST_LOW;
        ST_LOW: if (tick) begin
          sclk  <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk      <= 1'b0;
          wleft     <= wleft - CNT_W'(1);
          bits_left <= bits_left - BIT_W'(1);
          state     <= (wleft == CNT_W'(1)) ? ST_PUSH : ST_LOW;
        end
        ST_PUSH: if (!rx_full) begin
          rx_valid <= 1'b1;
          rx_data  <= rx_word;
          if (bits_left == '0) begin
            state <= ST_TAIL;
          end else begin
            next_bits <= CNT_W'(WORD_W);
            state     <= ST_FETCH;
          end
        end
        ST_TAIL: if (tick) begin
          cs_n <= 1'b1;
          if (reps_left == '0) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            reps_left <= reps_left - REP_W'(1);
            state     <= ST_GAP1;
          end
        end
        ST_GAP1: if (tick) state <= ST_GAP2;
        ST_GAP2: if (tick) begin
          bits_left <= BIT_W'(len_q) + BIT_W'(1);
          next_bits <= first_bits(len_q);
          state     <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
  parameter int unsigned HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_full,
  input logic sclk,
  input logic mosi,
  input logic cs_n
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)       hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + 16'd1;
    else           hi_cnt <= '0;
  end

  assert_sclk_idle_cs_R6: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_mosi_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_high_phase_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_cnt == 16'(HALF_DIV)));

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(rx_full));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !sclk);
endmodule

bind spi_burst_engine spi_burst_checker #(.HALF_DIV(HALF_DIV)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_full  (rx_full),
  .sclk     (sclk),
  .mosi     (mosi),
  .cs_n     (cs_n)
);

// File: tb/tb_spi_burst_engine.sv
module tb_spi_burst_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 12;
  localparam int REP_W    = 4;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] burst_len_m1 = '0;
  logic [REP_W-1:0] repeat_cnt = '0;
  logic busy, done, tx_ready, rx_valid, sclk, mosi, miso, cs_n;
  logic [WORD_W-1:0] tx_data, rx_data;
  logic tx_valid;
  logic rx_full = 1'b0;
  logic tx_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench FIFO and slave models
  logic [WORD_W-1:0] tx_mem [0:1023];
  logic [WORD_W-1:0] rx_mem [0:1023];
  logic mosi_cap  [0:16383];
  logic miso_bits [0:16383];
  int gap_mem [0:255];
  int tx_cnt = 0, tx_idx = 0, rx_n = 0, mosi_n = 0, miso_p = 0;
  int done_cnt = 0, fall_n = 0, gap_run = 0, hi_run = 0, last_hi = 0;
  int cs_high_rises = 0;
  logic cs_q = 1'b1;
  int checks = 0, failures = 0;
  int unsigned seed = 32'h1234_5678;

  assign tx_valid = (tx_idx < tx_cnt) && !tx_hold;
  assign tx_data  = tx_mem[tx_idx];
  assign miso     = miso_bits[miso_p];

  spi_burst_engine #(.WORD_W(WORD_W), .LEN_W(LEN_W), .REP_W(REP_W), .HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst(rst), .start(start), .burst_len_m1(burst_len_m1),
    .repeat_cnt(repeat_cnt), .busy(busy), .done(done),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    if (rx_valid) begin
      rx_mem[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
    if (!cs_n && cs_q) begin
      gap_mem[fall_n] <= gap_run;
      fall_n <= fall_n + 1;
    end
    if (!cs_n) gap_run <= 0;
    else if (busy) gap_run <= gap_run + 1;
    cs_q <= cs_n;
    if (sclk) hi_run <= hi_run + 1;
    else if (hi_run != 0) begin
      last_hi <= hi_run;
      hi_run <= 0;
    end
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      mosi_cap[mosi_n] <= mosi;
      mosi_n <= mosi_n + 1;
    end else begin
      cs_high_rises <= cs_high_rises + 1;
    end
    miso_p <= miso_p + 1;
  end

  function automatic int unsigned lcg(input int unsigned x);
    return x * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Queue words (with garbage in all 32 bits) for len/reps
  task automatic fill_tx(input int len, input int reps);
    int n = len + 1;
    int w = (n + 31) / 32;
    for (int i = 0; i < w * (reps + 1); i++) begin
      seed = lcg(seed);
      tx_mem[tx_cnt] = seed ^ (seed << 7);
      tx_cnt++;
    end
  endtask

  task automatic launch(input int len, input int reps);
    @(negedge clk);
    burst_len_m1 = LEN_W'(len);
    repeat_cnt   = REP_W'(reps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int base);
    int t = 0;
    while (done_cnt == base && t < 40000) begin
      @(negedge clk);
      t++;
    end
    check(done_cnt != base, "R10 run completes", done_cnt - base, 1);
    repeat (3) @(negedge clk);
  endtask

  // Compare captured streams against the packing rules
  task automatic check_run(input int len, input int reps, input int tx_b, input int mosi_b,
                           input int miso_b, input int rx_b, input int fall_b, input int done_b,
                           input string tag);
    int n = len + 1;
    int w = (n + 31) / 32;
    int m = (n % 32 == 0) ? 32 : n % 32;
    int k = mosi_b;
    int q = miso_b;
    int bad_tx = 0, bad_rx = 0;
    longint bad_tx_a = 0, bad_tx_e = 0, bad_rx_a = 0, bad_rx_e = 0;
    check(mosi_n - mosi_b == (reps + 1) * n, {"R1 bit count ", tag}, mosi_n - mosi_b, (reps + 1) * n);
    check(tx_idx - tx_b == (reps + 1) * w, {"R2 words popped ", tag}, tx_idx - tx_b, (reps + 1) * w);
    check(rx_n - rx_b == (reps + 1) * w, {"R5 words pushed ", tag}, rx_n - rx_b, (reps + 1) * w);
    for (int b = 0; b <= reps; b++) begin
      for (int j = 0; j < w; j++) begin
        int nb = (j == 0) ? m : 32;
        logic [31:0] word = tx_mem[tx_b + b * w + j];
        logic [31:0] exp_rx = '0;
        for (int i = nb - 1; i >= 0; i--) begin
          if (mosi_cap[k] !== word[i] && bad_tx == 0) begin
            bad_tx = 1; bad_tx_a = mosi_cap[k]; bad_tx_e = word[i];
          end
          k++;
        end
        for (int i = 0; i < nb; i++) begin
          exp_rx = {exp_rx[30:0], miso_bits[q]};
          q++;
        end
        if (rx_mem[rx_b + b * w + j] !== exp_rx && bad_rx == 0) begin
          bad_rx = 1; bad_rx_a = rx_mem[rx_b + b * w + j]; bad_rx_e = exp_rx;
        end
      end
    end
    check(bad_tx == 0, {"R2/R3/R4 mosi stream ", tag}, bad_tx_a, bad_tx_e);
    check(bad_rx == 0, {"R5 rx words ", tag}, bad_rx_a, bad_rx_e);
    check(fall_n - fall_b == reps + 1, {"R6 cs bursts ", tag}, fall_n - fall_b, reps + 1);
    check(cs_high_rises == 0, {"R6 no sclk with cs high ", tag}, cs_high_rises, 0);
    check(done_cnt - done_b == 1, {"R10 single done ", tag}, done_cnt - done_b, 1);
    check(!busy && cs_n && !sclk, {"R10 idle after run ", tag}, {busy, cs_n, sclk}, 3'b010);
  endtask

  task automatic run_plain(input int len, input int reps, input string tag);
    int tx_b = tx_idx, mosi_b = mosi_n, miso_b = miso_p, rx_b = rx_n;
    int fall_b = fall_n, done_b = done_cnt;
    fill_tx(len, reps);
    launch(len, reps);
    check(busy == 1'b1, {"R10 busy after start ", tag}, busy, 1);
    wait_done(done_b);
    check_run(len, reps, tx_b, mosi_b, miso_b, rx_b, fall_b, done_b, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0, "R12 pins after reset", {cs_n, sclk}, 2'b10);
    check(busy === 1'b0 && done === 1'b0, "R12 status after reset", {busy, done}, 0);
    check(tx_ready === 1'b0 && rx_valid === 1'b0, "R12 fifo ports after reset", {tx_ready, rx_valid}, 0);
  endtask

  task automatic t_half_period;
    check(last_hi == HALF_DIV, "R11 sclk high phase", last_hi, HALF_DIV);
  endtask

  task automatic t_repeat;
    int fall_b = fall_n;
    run_plain(11, 2, "repeat");
    for (int g = 1; g <= 2; g++)
      check(gap_mem[fall_b + g] >= 2 * HALF_DIV, "R7 cs gap between bursts",
            gap_mem[fall_b + g], 2 * HALF_DIV);
  endtask

  task automatic t_start_ignored;
    int tx_b = tx_idx, mosi_b = mosi_n, miso_b = miso_p, rx_b = rx_n;
    int fall_b = fall_n, done_b = done_cnt;
    fill_tx(15, 0);
    launch(15, 0);
    repeat (5) @(negedge clk);
    burst_len_m1 = LEN_W'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(done_b);
    check_run(15, 0, tx_b, mosi_b, miso_b, rx_b, fall_b, done_b, "R10 start while busy");
  endtask

  task automatic t_tx_stall;
    int tx_b = tx_idx, mosi_b = mosi_n, miso_b = miso_p, rx_b = rx_n;
    int fall_b = fall_n, done_b = done_cnt;
    int snap;
    fill_tx(63, 0);
    launch(63, 0);
    while (tx_idx == tx_b) @(negedge clk);
    tx_hold = 1'b1;
    repeat (200) @(negedge clk);
    snap = mosi_n;
    check(tx_ready === 1'b1 && sclk === 1'b0, "R8 waiting for tx word", {tx_ready, sclk}, 2'b10);
    repeat (50) @(negedge clk);
    check(mosi_n == snap && snap - mosi_b == 32, "R8 no edges while tx empty", mosi_n - mosi_b, 32);
    tx_hold = 1'b0;
    wait_done(done_b);
    check_run(63, 0, tx_b, mosi_b, miso_b, rx_b, fall_b, done_b, "R8 tx stall");
  endtask

  task automatic t_rx_stall;
    int tx_b = tx_idx, mosi_b = mosi_n, miso_b = miso_p, rx_b = rx_n;
    int fall_b = fall_n, done_b = done_cnt;
    fill_tx(63, 0);
    rx_full = 1'b1;
    launch(63, 0);
    repeat (300) @(negedge clk);
    check(rx_n == rx_b, "R9 no write while rx full", rx_n - rx_b, 0);
    check(mosi_n - mosi_b == 32 && sclk === 1'b0, "R9 sclk idle while rx full", mosi_n - mosi_b, 32);
    rx_full = 1'b0;
    wait_done(done_b);
    check_run(63, 0, tx_b, mosi_b, miso_b, rx_b, fall_b, done_b, "R9 rx stall");
  endtask

  initial begin
    bit wd_hit = 1'b0;
    for (int i = 0; i < 16384; i++) begin
      seed = lcg(seed);
      miso_bits[i] = seed[17];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      begin
        t_reset();
        run_plain(31, 0, "R2 one full word");
        t_half_period();
        run_plain(0, 0, "R3 single bit");
        run_plain(32, 0, "R2 33 bits");
        run_plain(69, 0, "R2 70 bits");
        t_repeat();
        t_start_ignored();
        t_tx_stall();
        t_rx_stall();
        run_plain(4095, 0, "R1 max length");
      end
      begin
        repeat (190000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule